// File: doc/BRIEF.md
# Multi-Channel SPI Control and Status Register File

This block is the memory-mapped front end of an SPI master that drives several chip-select channels. A simple synchronous port carries word reads and writes. Behind it sit a small set of global registers (revision, soft reset request, reset-done status and module mode) and one register bank per channel. Each bank holds configuration, status, control, transmit data and receive data. The shift engine that moves bits on the wire sits outside this block. It receives the decoded channel settings (clock phase and polarity, divider, word length, transfer direction and enable) and the transmit word. It reports word hand-offs back through single-cycle pulses.

Chip-select is under direct software control. A per-channel force bit asserts the select pin, and a polarity bit chooses its active level. Neither depends on the channel enable bit. Each channel also raises DMA write and read requests from its buffer flags, and each direction has its own configuration gate. A soft reset returns every bank and the module mode to their power-on values over a fixed number of cycles. A done flag reports when that sequence has finished.

Top module: `mspi_regfile`

## Requirements
- R1: After reset, sysstatus (0x14) bit 0 reads 1, module control (0x28) reads 0x4, every bank's configuration, control and RX data read 0, every bank's status reads 0x2 (TX empty only), and every chip-select pin, enable and DMA request is low.
- R2: Address 0x00 reads the REVISION parameter. Addresses 0x18, 0x1C, 0x20 and 0x24, and any address beyond the last bank, read 0, and writes to them change no register.
- R3: Module control keeps bits 0 (single channel), 2 (slave when 1) and 3 (system test) and reads every other bit as 0. Outputs mod_single, mod_slave and mod_systest follow those bits.
- R4: Bank i starts at 0x2C + 0x14*i and holds, at offsets +0x0/+0x4/+0x8/+0xC/+0x10, configuration, status, control, TX data and RX data. Configuration bits 20:0 read back and bits 31:21 read 0. The engine outputs decode bit 0 as phase, bit 1 as polarity, bits 5:2 as divider, bits 11:7 as word length minus one and bits 13:12 as transfer mode (01 receive only, 10 transmit only, 00 full duplex).
- R5: The chip-select pin of a channel equals configuration bit 20 (force) XOR bit 6 (select polarity). With polarity 1 the select is active low. The channel enable bit does not affect the pin.
- R6: A write to the TX data register places the word on eng_tx_data and clears status bit 1 (TX empty). An eng_tx_take pulse sets it again.
- R7: An eng_rx_load pulse stores eng_rx_data and sets status bit 0 (RX full). A bus read of the RX data register returns the stored word and clears RX full, unless a load arrives in the same cycle, in which case RX full stays set and the new word is kept.
- R8: An eng_eot pulse sets status bit 2 (end of transfer). A TX data write clears it.
- R9: dma_wr_req is configuration bit 14 AND TX empty AND control bit 0. dma_rd_req is configuration bit 15 AND RX full AND control bit 0.
- R10: Writing sysconfig (0x10) with bit 1 set makes sysstatus bit 0 read 0 from the next cycle. It reads 1 again after the RST_CYCLES-th clock edge following the write edge. Sysconfig bit 1 reads 1 while the sequence runs.
- R11: When the soft reset sequence completes, every bank and module control are back at their R1 values. Bus writes to banks or module control during the sequence are ignored.
- R12: Writes to the status and RX data registers have no effect. Control keeps only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe (side effects only; data is combinational) |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| mod_single | output | 1 | Single-channel mode |
| mod_slave | output | 1 | Slave mode when 1 |
| mod_systest | output | 1 | System test mode |
| eng_en | output | NUM_CH | Channel enable |
| eng_cpha | output | NUM_CH | Clock phase |
| eng_cpol | output | NUM_CH | Clock polarity |
| eng_clk_div | output | 4*NUM_CH | Divider code per channel |
| eng_wlen_m1 | output | 5*NUM_CH | Word length minus one per channel |
| eng_xfer_mode | output | 2*NUM_CH | Transfer direction per channel |
| eng_tx_data | output | DATA_W*NUM_CH | Transmit word per channel |
| eng_tx_take | input | NUM_CH | Engine consumed the transmit word |
| eng_rx_load | input | NUM_CH | Engine delivers a received word |
| eng_rx_data | input | DATA_W*NUM_CH | Received word per channel |
| eng_eot | input | NUM_CH | Engine finished shifting |
| cs_pin | output | NUM_CH | Chip-select pin level |
| dma_wr_req | output | NUM_CH | DMA request to fill TX |
| dma_rd_req | output | NUM_CH | DMA request to drain RX |

## Verification
The bench builds the block with three channels and an eight-cycle soft reset. With a non-power-of-two channel count, the last bank ends at an address that is not a natural boundary, so the bench can check the first address past it and see that a write there leaves the third bank untouched. Eight cycles is short enough to count every edge of the reset window and to land a rejected write inside it.

// File: rtl/mspi_pkg.sv
package mspi_pkg;

   // global register byte offsets
   localparam int unsigned OFS_REV     = 'h00;
   localparam int unsigned OFS_SYSCFG  = 'h10;
   localparam int unsigned OFS_SYSSTAT = 'h14;
   localparam int unsigned OFS_MODCTL  = 'h28;

   // channel bank placement
   localparam int unsigned BANK_BASE   = 'h2C;
   localparam int unsigned BANK_STRIDE = 'h14;

   // byte offsets inside a bank
   localparam int unsigned BK_CFG  = 'h00;
   localparam int unsigned BK_STAT = 'h04;
   localparam int unsigned BK_CTRL = 'h08;
   localparam int unsigned BK_TX   = 'h0C;
   localparam int unsigned BK_RX   = 'h10;

   // channel configuration word, bit 20 down to bit 0
   typedef struct packed {
      logic       force_cs;   // 20
      logic       turbo;      // 19
      logic       in_sel;     // 18
      logic       dpe1;       // 17
      logic       dpe0;       // 16
      logic       dma_rd_en;  // 15
      logic       dma_wr_en;  // 14
      logic [1:0] xfer_mode;  // 13:12
      logic [4:0] wlen_m1;    // 11:7
      logic       cs_low;     // 6
      logic [3:0] clk_div;    // 5:2
      logic       cpol;       // 1
      logic       cpha;       // 0
   } chan_cfg_t;

   localparam int unsigned CFG_W = $bits(chan_cfg_t);

endpackage

// File: rtl/mspi_sysctl.sv
module mspi_sysctl
   import mspi_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned RST_CYCLES = 8,
   parameter logic [31:0] REVISION   = 32'h0000_0021
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [3:0]        bus_wbits,
   output logic [DATA_W-1:0] rdata,
   output logic              busy,
   output logic              rst_done,
   output logic              mod_single,
   output logic              mod_slave,
   output logic              mod_systest
);

   localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);

   logic [CNT_W-1:0] cnt;
   logic             sel_syscfg, sel_modctl;

   assign sel_syscfg = (bus_addr == ADDR_W'(OFS_SYSCFG));
   assign sel_modctl = (bus_addr == ADDR_W'(OFS_MODCTL));
   assign busy       = (cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt         <= '0;
         rst_done    <= 1'b1;
         mod_single  <= 1'b0;
         mod_slave   <= 1'b1;
         mod_systest <= 1'b0;
      end else if (busy) begin
         cnt         <= cnt - 1'b1;
         mod_single  <= 1'b0;
         mod_slave   <= 1'b1;
         mod_systest <= 1'b0;
         if (cnt == CNT_W'(1)) rst_done <= 1'b1;
      end else if (bus_wr && sel_syscfg && bus_wbits[1]) begin
         cnt      <= CNT_W'(RST_CYCLES);
         rst_done <= 1'b0;
      end else if (bus_wr && sel_modctl) begin
         mod_single  <= bus_wbits[0];
         mod_slave   <= bus_wbits[2];
         mod_systest <= bus_wbits[3];
      end
   end

   always_comb begin
      rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_REV):     rdata = DATA_W'(REVISION);
         ADDR_W'(OFS_SYSCFG):  rdata = DATA_W'({busy, 1'b0});
         ADDR_W'(OFS_SYSSTAT): rdata = DATA_W'(rst_done);
         ADDR_W'(OFS_MODCTL):  rdata = DATA_W'({mod_systest, mod_slave, 1'b0, mod_single});
         default:              rdata = '0;
      endcase
   end

endmodule

// File: rtl/mspi_chan.sv
module mspi_chan
   import mspi_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BASE   = BANK_BASE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              tx_take,
   input  logic              rx_load,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              eot_in,
   output logic              en,
   output logic              cpha,
   output logic              cpol,
   output logic [3:0]        clk_div,
   output logic [4:0]        wlen_m1,
   output logic [1:0]        xfer_mode,
   output logic [DATA_W-1:0] tx_word,
   output logic              cs_pin,
   output logic              dma_wr_req,
   output logic              dma_rd_req
);

   chan_cfg_t         cfg;
   logic [DATA_W-1:0] rx_hold;
   logic              rx_full, tx_empty, eot_flag;
   logic [ADDR_W-1:0] rel;
   logic              s_cfg, s_stat, s_ctrl, s_tx, s_rx;
   logic              w_ok;

   // offset inside this bank; addresses below the base wrap above the stride
   assign rel    = bus_addr - ADDR_W'(BASE);
   assign s_cfg  = (rel == ADDR_W'(BK_CFG));
   assign s_stat = (rel == ADDR_W'(BK_STAT));
   assign s_ctrl = (rel == ADDR_W'(BK_CTRL));
   assign s_tx   = (rel == ADDR_W'(BK_TX));
   assign s_rx   = (rel == ADDR_W'(BK_RX));
   assign w_ok   = bus_wr && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg      <= '0;
         en       <= 1'b0;
         tx_word  <= '0;
         rx_hold  <= '0;
         rx_full  <= 1'b0;
         tx_empty <= 1'b1;
         eot_flag <= 1'b0;
      end else if (clr) begin
         cfg      <= '0;
         en       <= 1'b0;
         tx_word  <= '0;
         rx_hold  <= '0;
         rx_full  <= 1'b0;
         tx_empty <= 1'b1;
         eot_flag <= 1'b0;
      end else begin
         if (w_ok && s_cfg)  cfg <= chan_cfg_t'(bus_wdata[CFG_W-1:0]);
         if (w_ok && s_ctrl) en  <= bus_wdata[0];
         if (w_ok && s_tx) begin
            tx_word  <= bus_wdata;
            tx_empty <= 1'b0;
            eot_flag <= 1'b0;
         end else begin
            if (tx_take) tx_empty <= 1'b1;
            if (eot_in)  eot_flag <= 1'b1;
         end
         if (rx_load) begin
            rx_hold <= rx_word;
            rx_full <= 1'b1;
         end else if (bus_rd && s_rx) begin
            rx_full <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (s_cfg)  rdata = DATA_W'(cfg);
      if (s_stat) rdata = DATA_W'({eot_flag, tx_empty, rx_full});
      if (s_ctrl) rdata = DATA_W'(en);
      if (s_tx)   rdata = tx_word;
      if (s_rx)   rdata = rx_hold;
   end

   assign cpha       = cfg.cpha;
   assign cpol       = cfg.cpol;
   assign clk_div    = cfg.clk_div;
   assign wlen_m1    = cfg.wlen_m1;
   assign xfer_mode  = cfg.xfer_mode;
   assign cs_pin     = cfg.force_cs ^ cfg.cs_low;
   assign dma_wr_req = cfg.dma_wr_en & tx_empty & en;
   assign dma_rd_req = cfg.dma_rd_en & rx_full & en;

endmodule

// File: rtl/mspi_regfile.sv
module mspi_regfile
   import mspi_pkg::*;
#(
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned RST_CYCLES = 8,
   parameter logic [31:0] REVISION   = 32'h0000_0021
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic                     mod_single,
   output logic                     mod_slave,
   output logic                     mod_systest,
   output logic [NUM_CH-1:0]        eng_en,
   output logic [NUM_CH-1:0]        eng_cpha,
   output logic [NUM_CH-1:0]        eng_cpol,
   output logic [4*NUM_CH-1:0]      eng_clk_div,
   output logic [5*NUM_CH-1:0]      eng_wlen_m1,
   output logic [2*NUM_CH-1:0]      eng_xfer_mode,
   output logic [DATA_W*NUM_CH-1:0] eng_tx_data,
   input  logic [NUM_CH-1:0]        eng_tx_take,
   input  logic [NUM_CH-1:0]        eng_rx_load,
   input  logic [DATA_W*NUM_CH-1:0] eng_rx_data,
   input  logic [NUM_CH-1:0]        eng_eot,
   output logic [NUM_CH-1:0]        cs_pin,
   output logic [NUM_CH-1:0]        dma_wr_req,
   output logic [NUM_CH-1:0]        dma_rd_req
);

   localparam longint unsigned MAP_END = longint'(BANK_BASE) + longint'(NUM_CH) * longint'(BANK_STRIDE);

   initial begin : p_param_check
      assert (NUM_CH >= 1 && NUM_CH <= 16) else $fatal(1, "NUM_CH out of range");
      assert (ADDR_W >= 6 && ADDR_W <= 30) else $fatal(1, "ADDR_W out of range");
      assert (MAP_END <= (64'd1 << ADDR_W)) else $fatal(1, "banks exceed address space");
      assert (DATA_W >= 32) else $fatal(1, "DATA_W must hold a full register");
      assert (RST_CYCLES >= 1) else $fatal(1, "RST_CYCLES must be nonzero");
   end

   logic              soft_busy, rst_done;
   logic [DATA_W-1:0] sys_rdata;
   logic [DATA_W-1:0] ch_rdata [NUM_CH];

   mspi_sysctl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_CYCLES(RST_CYCLES), .REVISION(REVISION)
   ) u_sys (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wbits(bus_wdata[3:0]), .rdata(sys_rdata), .busy(soft_busy),
      .rst_done(rst_done), .mod_single(mod_single), .mod_slave(mod_slave),
      .mod_systest(mod_systest)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      mspi_chan #(
         .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BANK_BASE + i * BANK_STRIDE)
      ) u_chan (
         .clk(clk), .rst_n(rst_n), .clr(soft_busy),
         .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
         .rdata(ch_rdata[i]),
         .tx_take(eng_tx_take[i]), .rx_load(eng_rx_load[i]),
         .rx_word(eng_rx_data[i*DATA_W +: DATA_W]), .eot_in(eng_eot[i]),
         .en(eng_en[i]), .cpha(eng_cpha[i]), .cpol(eng_cpol[i]),
         .clk_div(eng_clk_div[i*4 +: 4]), .wlen_m1(eng_wlen_m1[i*5 +: 5]),
         .xfer_mode(eng_xfer_mode[i*2 +: 2]), .tx_word(eng_tx_data[i*DATA_W +: DATA_W]),
         .cs_pin(cs_pin[i]), .dma_wr_req(dma_wr_req[i]), .dma_rd_req(dma_rd_req[i])
      );
   end

   always_comb begin
      bus_rdata = sys_rdata;
      for (int i = 0; i < NUM_CH; i++) bus_rdata = bus_rdata | ch_rdata[i];
   end

endmodule

// File: rtl/mspi_regfile_chk.sv
module mspi_regfile_chk
   import mspi_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              srst_bit,
   input logic              soft_busy,
   input logic              rst_done,
   input logic [NUM_CH-1:0] eng_en,
   input logic [NUM_CH-1:0] eng_rx_load,
   input logic [NUM_CH-1:0] cs_pin,
   input logic [NUM_CH-1:0] dma_wr_req,
   input logic [NUM_CH-1:0] dma_rd_req
);

   // R10: a soft reset request drops the done flag on the next cycle
   p_srst_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_SYSCFG) && srst_bit && !soft_busy) |=> !rst_done);

   // R10: done never reads 1 while the sequence runs
   p_busy_not_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      soft_busy |-> !rst_done);

   // R11: banks are held quiet during the sequence
   p_srst_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_busy |=> (dma_wr_req == '0 && dma_rd_req == '0 && eng_en == '0));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(BANK_BASE + i * BANK_STRIDE + BK_CFG);
      localparam logic [ADDR_W-1:0] A_TX  = ADDR_W'(BANK_BASE + i * BANK_STRIDE + BK_TX);
      localparam logic [ADDR_W-1:0] A_RX  = ADDR_W'(BANK_BASE + i * BANK_STRIDE + BK_RX);

      // R9: no DMA request from a disabled channel
      p_dmawr_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
         dma_wr_req[i] |-> eng_en[i]);
      p_dmard_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
         dma_rd_req[i] |-> eng_en[i]);

      // R6: a TX write withdraws the fill request
      p_txwr_drops_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == A_TX && !soft_busy) |=> !dma_wr_req[i]);

      // R7: draining RX withdraws the read request unless a new word lands
      p_rxrd_drops_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == A_RX && !eng_rx_load[i] && !soft_busy) |=> !dma_rd_req[i]);

      // R5: select pin only moves on a configuration write
      p_cs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!soft_busy && !(bus_wr && bus_addr == A_CFG)) |=> $stable(cs_pin[i]));
   end

endmodule

bind mspi_regfile mspi_regfile_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
   .srst_bit(bus_wdata[1]), .soft_busy(soft_busy), .rst_done(rst_done),
   .eng_en(eng_en), .eng_rx_load(eng_rx_load), .cs_pin(cs_pin),
   .dma_wr_req(dma_wr_req), .dma_rd_req(dma_rd_req)
);

// File: tb/mspi_regfile_test.sv
`timescale 1ns/1ps
module mspi_regfile_test;

   localparam int NCH = 3;
   localparam int AW  = 8;
   localparam int DW  = 32;
   localparam logic [31:0] REV = 32'h0000_0021;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic [DW-1:0]   bus_wdata = '0;
   logic [DW-1:0]   bus_rdata;
   logic            mod_single, mod_slave, mod_systest;
   logic [NCH-1:0]  eng_en, eng_cpha, eng_cpol, cs_pin, dma_wr_req, dma_rd_req;
   logic [4*NCH-1:0] eng_clk_div;
   logic [5*NCH-1:0] eng_wlen_m1;
   logic [2*NCH-1:0] eng_xfer_mode;
   logic [DW*NCH-1:0] eng_tx_data;
   logic [NCH-1:0]  eng_tx_take = '0, eng_rx_load = '0, eng_eot = '0;
   logic [DW*NCH-1:0] eng_rx_data = '0;

   int checks = 0, fails = 0;

   always #2.5 clk = ~clk;

   mspi_regfile #(.NUM_CH(NCH), .ADDR_W(AW), .DATA_W(DW), .RST_CYCLES(8), .REVISION(REV)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mod_single(mod_single),
      .mod_slave(mod_slave), .mod_systest(mod_systest), .eng_en(eng_en),
      .eng_cpha(eng_cpha), .eng_cpol(eng_cpol), .eng_clk_div(eng_clk_div),
      .eng_wlen_m1(eng_wlen_m1), .eng_xfer_mode(eng_xfer_mode), .eng_tx_data(eng_tx_data),
      .eng_tx_take(eng_tx_take), .eng_rx_load(eng_rx_load), .eng_rx_data(eng_rx_data),
      .eng_eot(eng_eot), .cs_pin(cs_pin), .dma_wr_req(dma_wr_req), .dma_rd_req(dma_rd_req)
   );

   function automatic logic [AW-1:0] ba(int ch, int ofs);
      return AW'(32'h2C + 32'h14 * ch + ofs);
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      rd(8'h14, d); chk("R1 sysstatus", d, 1);
      rd(8'h28, d); chk("R1 modctl", d, 4);
      for (int c = 0; c < NCH; c++) begin
         rd(ba(c, 0), d);    chk("R1 cfg", d, 0);
         rd(ba(c, 4), d);    chk("R1 status", d, 2);
         rd(ba(c, 8), d);    chk("R1 ctrl", d, 0);
         rd(ba(c, 'h10), d); chk("R1 rxdata", d, 0);
      end
      chk("R1 pins", {cs_pin, eng_en, dma_wr_req, dma_rd_req}, 0);
   endtask

   task automatic t_globals();
      logic [DW-1:0] d;
      rd(8'h00, d); chk("R2 revision", d, REV);
      rd(8'h10, d); chk("R2 sysconfig idle", d, 0);
      for (int k = 0; k < 4; k++) begin
         wr(AW'(8'h18 + 4*k), 32'hFFFF_FFFF);
         rd(AW'(8'h18 + 4*k), d); chk("R2 unused global", d, 0);
      end
      wr(ba(NCH, 0), 32'hFFFF_FFFF);
      rd(ba(NCH, 0), d);      chk("R2 past last bank", d, 0);
      rd(ba(NCH-1, 0), d);    chk("R2 last bank untouched", d, 0);
      rd(ba(NCH-1, 'h10), d); chk("R2 last rx untouched", d, 0);
   endtask

   task automatic t_modctl();
      logic [DW-1:0] d;
      wr(8'h28, 32'hFFFF_FFFF);
      rd(8'h28, d); chk("R3 modctl all", d, 32'hD);
      chk("R3 mode outs", {mod_systest, mod_slave, mod_single}, 3'b111);
      wr(8'h28, 32'h1);
      rd(8'h28, d); chk("R3 master single", d, 1);
      chk("R3 mode outs master", {mod_systest, mod_slave, mod_single}, 3'b001);
      wr(8'h28, 32'h4);
   endtask

   task automatic t_cfg();
      logic [DW-1:0] d;
      wr(ba(1, 0), 32'hFFE0_17E9);
      rd(ba(1, 0), d); chk("R4 cfg readback", d, 32'h17E9);
      chk("R4 phase", eng_cpha[1], 1);
      chk("R4 polarity", eng_cpol[1], 0);
      chk("R4 divider", eng_clk_div[4 +: 4], 4'hA);
      chk("R4 wlen", eng_wlen_m1[5 +: 5], 5'd15);
      chk("R4 xfer mode", eng_xfer_mode[2 +: 2], 2'b01);
      rd(ba(0, 0), d); chk("R4 neighbour bank", d, 0);
      wr(ba(2, 0), 32'h001F_FFFF);
      rd(ba(2, 0), d); chk("R4 last bank cfg", d, 32'h001F_FFFF);
      chk("R4 last bank outs", {eng_xfer_mode[4 +: 2], eng_cpol[2]}, 3'b111);
      wr(ba(2, 0), 32'h0000_2000);
      chk("R4 tx only mode", eng_xfer_mode[4 +: 2], 2'b10);
      wr(ba(2, 0), 0);
      wr(ba(1, 0), 0);
   endtask

   task automatic t_cs();
      wr(ba(0, 0), 32'h40);      chk("R5 low polarity idle", cs_pin[0], 1);
      wr(ba(0, 0), 32'h10_0040); chk("R5 low polarity forced", cs_pin[0], 0);
      wr(ba(0, 8), 1);           chk("R5 enable no effect", cs_pin[0], 0);
      wr(ba(0, 0), 32'h10_0000); chk("R5 high polarity forced", cs_pin[0], 1);
      wr(ba(0, 0), 0);           chk("R5 enabled not forced", cs_pin[0], 0);
      wr(ba(0, 8), 0);
   endtask

   task automatic t_tx();
      logic [DW-1:0] d;
      wr(ba(0, 8), 1);
      wr(ba(0, 0), 32'h4000);
      chk("R9 write request", dma_wr_req[0], 1);
      wr(ba(0, 'hC), 32'hA5A5_0F0F);
      rd(ba(0, 4), d); chk("R6 status after tx write", d, 0);
      chk("R6 tx word", eng_tx_data[0 +: 32], 32'hA5A5_0F0F);
      chk("R9 write request dropped", dma_wr_req[0], 0);
      @(negedge clk) eng_tx_take[0] = 1'b1;
      @(negedge clk) eng_tx_take[0] = 1'b0;
      rd(ba(0, 4), d); chk("R6 take sets empty", d, 2);
      chk("R9 write request back", dma_wr_req[0], 1);
      @(negedge clk) eng_eot[0] = 1'b1;
      @(negedge clk) eng_eot[0] = 1'b0;
      rd(ba(0, 4), d); chk("R8 eot set", d, 6);
      wr(ba(0, 'hC), 32'h1);
      rd(ba(0, 4), d); chk("R8 eot cleared by tx write", d, 0);
      wr(ba(0, 4), 32'hFFFF_FFFF);
      rd(ba(0, 4), d); chk("R12 status write ignored", d, 0);
      wr(ba(0, 8), 32'hFFFF_FFFF);
      rd(ba(0, 8), d); chk("R12 ctrl keeps bit0", d, 1);
      wr(ba(0, 8), 0);
      chk("R9 disabled no write request", dma_wr_req[0], 0);
   endtask

   task automatic t_rx();
      logic [DW-1:0] d;
      wr(ba(1, 8), 1);
      wr(ba(1, 0), 32'h8000);
      chk("R9 no read request when empty", dma_rd_req[1], 0);
      @(negedge clk) begin eng_rx_load[1] = 1'b1; eng_rx_data[32 +: 32] = 32'h1234; end
      @(negedge clk) eng_rx_load[1] = 1'b0;
      rd(ba(1, 4), d); chk("R7 rx full set", d, 3);
      chk("R9 read request", dma_rd_req[1], 1);
      wr(ba(1, 8), 0);
      chk("R9 read request gated by enable", dma_rd_req[1], 0);
      wr(ba(1, 8), 1);
      wr(ba(1, 'h10), 32'h5555);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = ba(1, 'h10);
      #1 d = bus_rdata;
      @(negedge clk) bus_rd = 1'b0;
      chk("R12 rx write ignored, R7 data", d, 32'h1234);
      rd(ba(1, 4), d); chk("R7 rx full cleared by read", d, 2);
      chk("R7 read request dropped", dma_rd_req[1], 0);
      @(negedge clk) begin eng_rx_load[1] = 1'b1; eng_rx_data[32 +: 32] = 32'h9999; end
      @(negedge clk) eng_rx_load[1] = 1'b0;
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = ba(1, 'h10);
      eng_rx_load[1] = 1'b1; eng_rx_data[32 +: 32] = 32'hBEEF;
      #1 d = bus_rdata;
      @(negedge clk) begin bus_rd = 1'b0; eng_rx_load[1] = 1'b0; end
      chk("R7 old word on collision", d, 32'h9999);
      rd(ba(1, 4), d); chk("R7 load wins collision", d[0], 1);
      rd(ba(1, 'h10), d); chk("R7 new word kept", d, 32'hBEEF);
      wr(ba(1, 8), 0);
      wr(ba(1, 0), 0);
   endtask

   task automatic t_srst();
      logic [DW-1:0] d;
      wr(ba(0, 0), 32'h10_0000);
      wr(ba(0, 8), 1);
      wr(8'h28, 32'h9);
      chk("R11 pre pin", cs_pin[0], 1);
      wr(8'h10, 32'h2);
      peek(8'h14, d); chk("R10 done low after request", d, 0);
      peek(8'h10, d); chk("R10 sysconfig busy", d, 2);
      wr(ba(0, 0), 32'h40);
      repeat (5) @(negedge clk);
      peek(8'h14, d); chk("R10 done low at edge 7", d, 0);
      @(negedge clk);
      peek(8'h14, d); chk("R10 done at edge 8", d, 1);
      rd(ba(0, 0), d); chk("R11 cfg cleared, write ignored", d, 0);
      rd(ba(0, 4), d); chk("R11 status reset", d, 2);
      rd(ba(0, 8), d); chk("R11 ctrl reset", d, 0);
      rd(8'h28, d);    chk("R11 modctl reset", d, 4);
      chk("R11 pin idle", cs_pin[0], 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_globals();
      t_modctl();
      t_cfg();
      t_cs();
      t_tx();
      t_rx();
      t_srst();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #500000;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule